// File: doc/BRIEF.md
# Single-Precision to Reduced Float Field Packer

This block takes one IEEE-754 single-precision word and turns it into a narrower floating-point code. The exponent width, the mantissa width and the presence of a sign bit are parameters. The code is placed at a parameter bit offset inside a 32-bit output word, and every other bit of that word is zero. Several instances with offsets that do not overlap can therefore be ORed together to build a packed pixel word. One example is an unsigned 11/11/10 color word: red uses 6 mantissa and 5 exponent bits at offset 0, green uses the same widths at offset 11, and blue uses 5 mantissa and 5 exponent bits at offset 22.

The conversion truncates toward zero. The exponent is rebiased from 127 to 2^(E-1)-1. Values below the smallest normal of the target format become denormals, and any bits shifted out are dropped. A finite magnitude that is too large saturates to the largest finite code and never becomes infinity. NaN and infinity are carried through as special codes. In the unsigned variant, negative inputs clamp to zero. In the signed variant, the input sign bit is kept.

There is one register stage. A valid strobe travels with the data.

Top module: `f32_minifloat_pack`

## Requirements
- R1: `out_valid` equals `in_valid` from one cycle earlier. `out_word` loads the converted value only on a cycle with `in_valid` high and holds otherwise. Reset clears both outputs to zero.
- R2: For a finite normal result, the exponent field is the input exponent minus 127 plus 2^(E-1)-1. The mantissa field is the top M input fraction bits, and the lower fraction bits are discarded with no rounding increment.
- R3: A finite input whose rebiased exponent is 2^E-1 or larger gives an exponent field of 2^E-2 and a mantissa field of all ones. A finite input never gives an all-ones exponent field.
- R4: When the rebiased exponent is 0 or below, the mantissa field is the 24-bit significand with its hidden one, shifted right by 24-M minus the rebiased exponent and truncated. The exponent field is 0. A result that shifts out completely is zero, and input denormals and ±0 give a zero magnitude.
- R5: Any NaN input (exponent 255 with a nonzero fraction) gives an all-ones exponent field and a mantissa field of only its top bit set. In the unsigned variant this holds for either input sign.
- R6: +Inf gives an all-ones exponent field and a zero mantissa field. In the signed variant, -Inf gives the same magnitude with the sign bit set.
- R7: In the unsigned variant, every negative input that is not a NaN gives a zero field. This includes -0, negative finite values and -Inf.
- R8: In the signed variant, bit E+M of the field is the input sign bit for every input, including -0 and NaN. The magnitude is computed from the absolute value.
- R9: The field occupies bits FIELD_LSB up to FIELD_LSB+M+E+S-1 of `out_word`, with the mantissa in its low bits and the exponent directly above it. All other bits of `out_word` are zero.
- R10: Three unsigned instances with widths (M=6,E=5) at offset 0, (6,5) at offset 11 and (5,5) at offset 22, ORed together, give the 11/11/10 packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_f32 | input | 32 | Single-precision input value |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 32 | Converted field at its offset, other bits zero |

## Verification
The bench builds four instances. The first is a signed variant with 5 exponent and 10 mantissa bits placed at offset 4, which brings the kept sign bit and a field with a gap below it within reach. The other three are the unsigned red, green and blue variants of the 11/11/10 word, one of which has a 5-bit mantissa. Every input exponent from 0 to 255 is swept with both signs under a set of fraction patterns, so every rebias boundary, every denormal shift distance, the saturation edge and all NaN and infinity codes are reached in every configuration. Random words are then applied on top of the sweep.

// File: rtl/f32_minifloat_pack.sv
module f32_minifloat_pack #(
  parameter int MANT_W    = 6,
  parameter int EXP_W     = 5,
  parameter bit SIGNED    = 1'b0,
  parameter int FIELD_LSB = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_f32,
  output logic        out_valid,
  output logic [31:0] out_word
);

  localparam int SGN_W = SIGNED ? 1 : 0;
  localparam int FW    = MANT_W + EXP_W + SGN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [9:0] REBIAS = 10'(BIAS - 127);
  localparam logic signed [9:0] RE_SAT = 10'((1 << EXP_W) - 1);
  localparam logic [9:0] DEN_BASE = 10'(24 - MANT_W);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_TOP  = {{(EXP_W-1){1'b1}}, 1'b0};
  localparam logic [31:0] FIELD_MASK = 32'(((64'(1) << FW) - 64'(1)) << FIELD_LSB);
  localparam int EXP_LSB = FIELD_LSB + MANT_W;

  logic                      sgn;
  logic [7:0]                ex;
  logic [22:0]               fr;
  logic                      is_nan, is_inf;
  logic signed [9:0]         re;
  logic [9:0]                dsh;
  logic [MANT_W-1:0]         den;
  logic [EXP_W+MANT_W-1:0]   mag;
  logic [FW-1:0]             field;
  logic [31:0]               word_c;

  assign sgn    = in_f32[31];
  assign ex     = in_f32[30:23];
  assign fr     = in_f32[22:0];
  assign is_nan = (ex == 8'hFF) && (fr != 23'd0);
  assign is_inf = (ex == 8'hFF) && (fr == 23'd0);
  assign re     = $signed({2'b00, ex}) + REBIAS;
  assign dsh    = DEN_BASE - $unsigned(re);
  assign den    = MANT_W'({1'b1, fr} >> dsh);

  always_comb begin
    if (is_nan)                mag = {EXP_ONES, 1'b1, {(MANT_W-1){1'b0}}};
    else if (is_inf)           mag = {EXP_ONES, {MANT_W{1'b0}}};
    else if (ex == 8'h00)      mag = '0;
    else if (re >= RE_SAT)     mag = {EXP_TOP, {MANT_W{1'b1}}};
    else if (re > 10'sd0)      mag = {re[EXP_W-1:0], fr[22 -: MANT_W]};
    else                       mag = {{EXP_W{1'b0}}, den};
  end

  generate
    if (SIGNED) begin : g_sgn
      assign field = {sgn, mag};
    end else begin : g_uns
      assign field = (sgn && !is_nan) ? '0 : mag;
    end
  endgenerate

  assign word_c = 32'(field) << FIELD_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= word_c;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
  a_r9_field_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_word & ~FIELD_MASK) == 32'd0);
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_f32[30:23] == 8'hFF && in_f32[22:0] != 23'd0) |=>
      (out_word[EXP_LSB +: EXP_W] == EXP_ONES) && out_word[EXP_LSB-1]);
  a_r3_no_inf_from_finite: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_f32[30:23] != 8'hFF) |=> out_word[EXP_LSB +: EXP_W] != EXP_ONES);

  generate
    if (SIGNED) begin : g_sgn_chk
      a_r8_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[FIELD_LSB+EXP_W+MANT_W] == $past(in_f32[31]));
    end else begin : g_uns_chk
      a_r7_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_f32[31] && !(in_f32[30:23] == 8'hFF && in_f32[22:0] != 23'd0))
          |=> out_word == 32'd0);
    end
  endgenerate

endmodule

// File: tb/test_f32_minifloat_pack.sv
module test_f32_minifloat_pack;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] xh = '0, xr = '0, xg = '0, xb = '0;
  logic vh, vr, vg, vb;
  logic [31:0] oh, orr, og, ob;
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  f32_minifloat_pack #(.MANT_W(10), .EXP_W(5), .SIGNED(1'b1), .FIELD_LSB(4)) i_f32_minifloat_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_f32(xh), .out_valid(vh), .out_word(oh));
  f32_minifloat_pack #(.MANT_W(6), .EXP_W(5), .SIGNED(1'b0), .FIELD_LSB(0)) i_f32_minifloat_pack_r (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_f32(xr), .out_valid(vr), .out_word(orr));
  f32_minifloat_pack #(.MANT_W(6), .EXP_W(5), .SIGNED(1'b0), .FIELD_LSB(11)) i_f32_minifloat_pack_g (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_f32(xg), .out_valid(vg), .out_word(og));
  f32_minifloat_pack #(.MANT_W(5), .EXP_W(5), .SIGNED(1'b0), .FIELD_LSB(22)) i_f32_minifloat_pack_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_f32(xb), .out_valid(vb), .out_word(ob));

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [31:0] ref_code(input logic [31:0] x, input int m, input int e, input bit sg);
    int bias = (1 << (e - 1)) - 1;
    int ex = int'(x[30:23]);
    int kmax = (1 << e) - 2 - bias;
    logic [31:0] sb = sg ? (32'(x[31]) << (e + m)) : 32'd0;
    logic [31:0] ones = 32'((1 << e) - 1);
    real v, q;
    int k, mant, expf;
    if (ex == 255 && x[22:0] != 0) return sb | (ones << m) | (32'd1 << (m - 1));
    if (!sg && x[31]) return 32'd0;
    if (ex == 255) return sb | (ones << m);
    if (ex == 0) v = real'(x[22:0]) * pow2(-149);
    else         v = (8388608.0 + real'(x[22:0])) * pow2(ex - 150);
    k = 1 - bias;
    if (v < pow2(k)) begin
      q = $floor(v / pow2(k - m));
      mant = int'(q);
      expf = 0;
    end else begin
      while (k < kmax && v >= pow2(k + 1)) k++;
      q = $floor(v / pow2(k - m));
      if (q > pow2(m + 1) - 1.0) q = pow2(m + 1) - 1.0;
      mant = int'(q) - (1 << m);
      expf = k + bias;
    end
    return sb | (32'(expf) << m) | 32'(mant);
  endfunction

  function automatic string req_of(input logic [31:0] x, input bit sg);
    if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? "R5" : "R6";
    if (!sg && x[31]) return "R7";
    if (x[30:23] >= 8'd143) return "R3";
    if (x[30:23] <= 8'd112) return "R4";
    return "R2";
  endfunction

  task automatic cmp(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x);
    logic [31:0] eh, er, eg, eb;
    @(negedge clk);
    xh = x; xr = x; xg = {x[31:23], ~x[22:0]}; xb = x ^ 32'h8000_0000;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    eh = ref_code(xh, 10, 5, 1'b1) << 4;
    er = ref_code(xr, 6, 5, 1'b0);
    eg = ref_code(xg, 6, 5, 1'b0) << 11;
    eb = ref_code(xb, 5, 5, 1'b0) << 22;
    cmp("R1", {31'd0, vh & vr & vg & vb}, 32'd1, "out_valid after accept");
    cmp(xh[31] ? "R8" : req_of(xh, 1'b1), oh, eh, "signed E5M10 @4 (R9 placement)");
    cmp(req_of(xr, 1'b0), orr, er, "red E5M6 @0");
    cmp(req_of(xg, 1'b0), og, eg, "green E5M6 @11");
    cmp(req_of(xb, 1'b0), ob, eb, "blue E5M5 @22");
    cmp("R10", orr | og | ob, er | eg | eb, "packed 11/11/10 word");
  endtask

  function automatic logic [22:0] pattern(input int p);
    case (p)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7FFFFF;
      4: return 23'h2AAAAA;
      5: return 23'h555555;
      6: return 23'h001FFF;
      7: return 23'h7FE000;
      8: return 23'h3F0001;
      default: return 23'h020000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    cmp("R1", {31'd0, vh | vr | vg | vb}, 32'd0, "valid in reset");
    cmp("R1", oh | orr | og | ob, 32'd0, "word in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", {31'd0, vh}, 32'd0, "valid idle after reset");

    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int p = 0; p < 10; p++)
          apply({s[0], e[7:0], pattern(p)});

    for (int i = 0; i < 2000; i++) apply($urandom);

    // R1: hold when idle with a changed input
    for (int i = 0; i < 8; i++) begin
      apply(32'h3FC0_0000 + 32'(i) * 32'h0100_0000);
      held = oh;
      xh = 32'h7FC0_0000; xr = 32'hFF80_0000; xg = 32'h0; xb = 32'h4000_0000;
      @(negedge clk);
      cmp("R1", {31'd0, vh}, 32'd0, "valid drops when idle");
      cmp("R1", oh, held, "word holds when idle");
    end

    // Named corner cases
    apply(32'h8000_0000); cmp("R8", oh, 32'h0008_0000, "signed -0 keeps sign");
    apply(32'hFFC0_0001); cmp("R5", orr, 32'h0000_07E0, "negative NaN is positive quiet");
    apply(32'h7F7F_FFFF); cmp("R3", orr, 32'h0000_07BF, "max float saturates");
    apply(32'h3800_0000); cmp("R4", orr, 32'h0000_0020, "2^-15 denormal top bit");
    apply(32'h3380_0000); cmp("R4", orr, 32'h0000_0000, "shifted out fully");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule